// File: doc/BRIEF.md
# Serial-Programmed Switch Control Register

This block is the digital front end for an array of eight transmit/receive switches that also takes a programmable bias-current setting. A host shifts a 12-bit control word in over a three-wire serial link made of a serial clock, serial data in and serial data out. The word sits in a shift register until the host drops the active-low load input. While the load input is low, a level-transparent latch copies the shift register contents to the switch-enable outputs and the bias-code output. While it is high, the latch holds its contents.

An asynchronous clear input empties the latch at once, turns every switch off and raises a shutdown output. The shift register is left as it is, so a later load pulse restores the word that was shifted in before the clear. The serial output is the last stage of the shift register. Several devices can therefore share the serial clock, load and clear lines, with each serial output wired to the next device's serial input. The serial inputs are sampled in the system clock domain through a synchronizer, and serial-clock rising edges are detected after synchronization.

Top module: `swctl_serial_top`

## Requirements
- R1: While reset is asserted, and after it is released, the shift register and the latch are both zero. All switch enables and the bias code read zero, and a load pulse directly after reset still yields all zeros.
- R2: Every rising edge of the synchronized serial clock shifts serial data in at bit 0 and moves each stage up by one. The word is therefore sent most significant bit first, and after 12 edges it occupies the register completely.
- R3: The serial output is the top stage (bit 11) of the shift register. A bit entered on one serial-clock edge appears on the serial output after the eleventh following edge, so the next device in a chain captures it exactly 12 edges after it was entered.
- R4: While the load input is low and clear is low, the latch follows the shift register, and each shift shows up on the outputs.
- R5: While the load input is high, the switch enables and the bias code keep their values, including while new data is being shifted in.
- R6: Raising clear forces the latch to zero without waiting for a clock edge. Every switch enable and the whole bias code then read zero. Clear overrides a low load input.
- R7: Clear does not change the shift register. After clear falls, a load pulse puts the word shifted in before the clear back on the outputs.
- R8: Bits 0 to 7 of the latched word drive switch enables 1 to 8 in that order (output bit i = word bit i, 1 = switch on). Bits 8 to 11 form the 4-bit bias code, with word bit 11 as the code's most significant bit.
- R9: The shutdown output is high whenever clear is high or reset is asserted, and low otherwise.
- R10: In a chain of three devices, a 36-bit stream followed by one load pulse leaves the first 12 bits sent in the last device, the middle 12 in the middle device and the last 12 in the first device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all serial inputs are sampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data shifts on its rising edge |
| ser_din | input | 1 | Serial data in, most significant bit first |
| ser_dout | output | 1 | Serial data out, the top shift stage, for chaining |
| load_n | input | 1 | Active-low load; latch is transparent while low |
| clear | input | 1 | Active-high clear; empties the latch asynchronously |
| sw_en | output | 8 | Switch enables, bit i controls switch i+1 |
| bias_code | output | 4 | Bias-current code from word bits 11..8 |
| shutdown | output | 1 | High during clear or reset |

## Verification
The bench builds the block with its defaults of eight switch bits, a four-bit bias field and a two-stage synchronizer, and chains three instances so that one 36-bit stream reaches every stage boundary of every register. It sweeps all sixteen bias codes with computed switch patterns in each device. At this size, the full word-to-output mapping and the 12-edge chain delay can be checked against an arithmetic model of the concatenated shift registers. Clear is raised between clock edges, so the asynchronous emptying of the latch is visible before the next edge, and it is also combined with a low load input.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
   localparam int unsigned SWCTL_DEF_SWITCHES = 8;
   localparam int unsigned SWCTL_DEF_BIAS_W   = 4;
   localparam int unsigned SWCTL_DEF_SYNC     = 2;

   function automatic int unsigned swctl_word_w(input int unsigned n_sw,
                                                input int unsigned bias_w);
      return n_sw + bias_w;
   endfunction
endpackage

// File: rtl/swctl_sync.sv
module swctl_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("swctl_sync: W must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
         end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/swctl_shifter.sv
module swctl_shifter #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sclk_s,
   input  logic         din_s,
   output logic [W-1:0] word,
   output logic         dout
);
   if (W < 2) begin : g_bad_w
      $error("swctl_shifter: W must be at least 2");
   end

   logic         sclk_q;
   logic         rise;
   logic [W-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end

   assign rise = sclk_s & ~sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sr <= '0;
      else if (rise) sr <= {sr[W-2:0], din_s};
   end

   assign word = sr;
   assign dout = sr[W-1];

   // R7: with no serial edge the register keeps its contents, clear or not
   a_r7_sr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !rise |=> $stable(word));

   // R3: the output stage takes the value held one position below it
   a_r3_dout_stage: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> dout == $past(word[W-2]));
endmodule

// File: rtl/swctl_latch.sv
module swctl_latch #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_a,
   input  logic         load_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n or posedge clr_a) begin
      if (!rst_n)       q <= '0;
      else if (clr_a)   q <= '0;
      else if (!load_n) q <= d;
   end

   // R5: held while load is high
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (load_n && !clr_a) |=> (clr_a || $stable(q)));

   // R4: transparent while load is low
   a_r4_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n && !clr_a) |=> (clr_a || q == $past(d)));
endmodule

// File: rtl/swctl_serial_top.sv
module swctl_serial_top #(
   parameter int unsigned N_SW        = swctl_pkg::SWCTL_DEF_SWITCHES,
   parameter int unsigned BIAS_W      = swctl_pkg::SWCTL_DEF_BIAS_W,
   parameter int unsigned SYNC_STAGES = swctl_pkg::SWCTL_DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_clk,
   input  logic              ser_din,
   output logic              ser_dout,
   input  logic              load_n,
   input  logic              clear,
   output logic [N_SW-1:0]   sw_en,
   output logic [BIAS_W-1:0] bias_code,
   output logic              shutdown
);
   localparam int unsigned WORD_W = swctl_pkg::swctl_word_w(N_SW, BIAS_W);

   if (N_SW < 1 || N_SW > 64) begin : g_bad_sw
      $error("swctl_serial_top: N_SW out of range");
   end
   if (BIAS_W < 1 || BIAS_W > 16) begin : g_bad_bias
      $error("swctl_serial_top: BIAS_W out of range");
   end

   logic [2:0]        raw_in;
   logic [2:0]        syn_in;
   logic [WORD_W-1:0] sh_word;
   logic [WORD_W-1:0] lat_word;

   assign raw_in = {load_n, ser_din, ser_clk};

   swctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (syn_in)
   );

   swctl_shifter #(.W(WORD_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_s (syn_in[0]),
      .din_s  (syn_in[1]),
      .word   (sh_word),
      .dout   (ser_dout)
   );

   swctl_latch #(.W(WORD_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_a  (clear),
      .load_n (syn_in[2]),
      .d      (sh_word),
      .q      (lat_word)
   );

   for (genvar i = 0; i < N_SW; i++) begin : g_sw
      assign sw_en[i] = lat_word[i];
   end
   for (genvar j = 0; j < BIAS_W; j++) begin : g_bias
      assign bias_code[j] = lat_word[N_SW + j];
   end

   assign shutdown = clear | ~rst_n;

   // R6: clear leaves every output empty
   a_r6_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
      clear |-> (sw_en == '0 && bias_code == '0));
endmodule

// File: tb/test_swctl_serial_top.sv
module test_swctl_serial_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, sclk, sdi, load_n, clr;
   logic [2:0] dout;
   logic [2:0] dins;
   logic [7:0] sw [0:2];
   logic [3:0] bs [0:2];
   logic [2:0] sd;
   logic [35:0] model;
   int tests = 0;
   int fails = 0;

   assign dins = {dout[1], dout[0], sdi};

   for (genvar k = 0; k < 3; k++) begin : g_dev
      swctl_serial_top i_swctl_serial_top (
         .clk       (clk),
         .rst_n     (rst_n),
         .ser_clk   (sclk),
         .ser_din   (dins[k]),
         .ser_dout  (dout[k]),
         .load_n    (load_n),
         .clear     (clr),
         .sw_en     (sw[k]),
         .bias_code (bs[k]),
         .shutdown  (sd[k])
      );
   end

   task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b);
      sdi = b;
      tick(4);
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      model = {model[34:0], b};
   endtask

   task automatic send_word(input logic [11:0] w);
      for (int i = 11; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic pulse_load();
      load_n = 1'b0;
      tick(4);
      load_n = 1'b1;
      tick(6);
   endtask

   function automatic logic [11:0] out_word(input int k);
      return {bs[k], sw[k]};
   endfunction

   task automatic chk_devs(input string tag);
      for (int k = 0; k < 3; k++) begin
         logic [11:0] w;
         w = model[12*k +: 12];
         chk(sw[k] == w[7:0], {tag, " R8 switches"}, 36'(sw[k]), 36'(w[7:0]));
         chk(bs[k] == w[11:8], {tag, " R8 bias"}, 36'(bs[k]), 36'(w[11:8]));
      end
   endtask

   task automatic chk_zero(input string tag);
      for (int k = 0; k < 3; k++)
         chk(out_word(k) == 12'h0, tag, 36'(out_word(k)), 36'h0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [35:0] prev;
      rst_n = 1'b0; sclk = 1'b0; sdi = 1'b0; load_n = 1'b1; clr = 1'b0;
      model = '0;
      tick(3);
      chk_zero("R1 reset outputs");
      chk(sd == 3'b111, "R9 shutdown in reset", 36'(sd), 36'h7);
      rst_n = 1'b1;
      tick(4);
      chk(sd == 3'b000, "R9 shutdown released", 36'(sd), 36'h0);
      chk(dout == 3'b000, "R1 serial out after reset", 36'(dout), 36'h0);

      // shift with load high: outputs frozen, serial out tracks the model
      send_word(12'h9A5); send_word(12'h3C6); send_word(12'hE71);
      chk_zero("R5 frozen during shift");
      chk(dout[2] == model[35], "R3 chain tail out", 36'(dout[2]), 36'(model[35]));
      chk(dout[0] == model[11], "R3 first device out", 36'(dout[0]), 36'(model[11]));
      pulse_load();
      chk_devs("R10 chain load");
      chk(out_word(2) == 12'h9A5, "R10 first word in last device", 36'(out_word(2)), 36'h9A5);
      chk(out_word(0) == 12'hE71, "R2 last word in first device", 36'(out_word(0)), 36'hE71);

      // per-bit serial-out timing over a second stream, outputs held
      prev = {out_word(2), out_word(1), out_word(0)};
      for (int i = 0; i < 36; i++) begin
         send_bit(((i * 7) % 5) < 2);
         chk(dout[2] == model[35], "R3 per-bit tail", 36'(dout[2]), 36'(model[35]));
         chk(dout[0] == model[11], "R3 per-bit head", 36'(dout[0]), 36'(model[11]));
      end
      chk({out_word(2), out_word(1), out_word(0)} == prev, "R5 hold nonzero",
          {out_word(2), out_word(1), out_word(0)}, prev);

      // asynchronous clear
      pulse_load();
      clr = 1'b1;
      #1;
      chk_zero("R6 async clear");
      chk(sd == 3'b111, "R9 shutdown on clear", 36'(sd), 36'h7);
      @(negedge clk);
      load_n = 1'b0;
      tick(5);
      chk_zero("R6 clear beats load");
      load_n = 1'b1;
      tick(3);
      clr = 1'b0;
      tick(4);
      chk_zero("R6 latch stays empty");
      chk(sd == 3'b000, "R9 shutdown after clear", 36'(sd), 36'h0);
      pulse_load();
      chk_devs("R7 restore after clear");

      // transparency while load is low
      load_n = 1'b0;
      for (int i = 0; i < 12; i++) begin
         send_bit(i[0] ^ i[2]);
         chk(out_word(0) == model[11:0], "R4 transparent dev0", 36'(out_word(0)), 36'(model[11:0]));
         chk(out_word(1) == model[23:12], "R4 transparent dev1", 36'(out_word(1)), 36'(model[23:12]));
      end
      load_n = 1'b1;
      tick(4);

      // sweep every bias code with computed switch patterns
      for (int it = 0; it < 16; it++) begin
         logic [7:0] p;
         p = 8'((it * 37 + 5) & 255);
         send_word({4'(15 - it), ~p});
         send_word({4'(it ^ 5), 8'(p ^ 8'h5A)});
         send_word({4'(it), p});
         pulse_load();
         chk_devs("R8 sweep");
         chk(bs[0] == 4'(it), "R8 bias code value", 36'(bs[0]), 36'(it));
      end

      // reset mid-operation clears both shift register and latch
      rst_n = 1'b0;
      tick(2);
      chk_zero("R1 reset clears latch");
      rst_n = 1'b1;
      model = '0;
      tick(4);
      pulse_load();
      chk_zero("R1 reset clears shift register");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule